// File: doc/BRIEF.md
# Lite Serial Port Register Block

This block is the processor-facing side of a minimal serial port. A simple strobe bus reaches four word-aligned registers. Received bytes arrive on a byte-wide stream with a valid/ready handshake and are queued in a small circular FIFO. The processor drains that FIFO one byte per read of the receive-data register. Bytes the processor writes to the transmit-data register go into a single holding register and leave on an outgoing byte stream with a valid/ready handshake. The serial shifters and the baud timing sit outside the block, on those two streams.

A status word reports the state of both directions. A sticky pending flag feeds a level interrupt, which an enable bit in the control register gates. Writing the control register can also empty the receive FIFO or discard the byte in the transmit holding register.

Top module: `serial_port_regs`

## Requirements
- R1: The register is selected by address bits [3:2]: 0 selects receive data, 1 transmit data, 2 status and 3 control. Address bits above bit 3 must be zero. Read data is registered and appears on `bus_rdata` one cycle after `bus_rd_en`. A read of an unmapped address returns zero.
- R2: The status word has this layout: bit 0 is set when the receive FIFO is not empty, bit 1 when it holds 8 bytes, bit 2 when the transmit holding register is empty, bit 3 when it is occupied, bit 4 is the pending flag and bit 5 is overrun. All other bits read 0.
- R3: The receive FIFO holds up to 8 bytes and returns them in arrival order, across pointer wrap. `rx_ready` is high exactly while fewer than 8 bytes are held.
- R4: A byte offered while the FIFO is full is discarded and sets overrun. A status read clears overrun. If a set and a clear fall in the same cycle, the set wins.
- R5: A read of the receive-data register returns the oldest byte and removes it. A read while the FIFO is empty returns 0 and leaves the count at zero.
- R6: Writing control with bit 1 set empties the receive FIFO. This takes priority over a push in the same cycle.
- R7: A transmit-data write while the holding register is empty loads `bus_wdata[7:0]`, and `tx_valid` rises in the next cycle. The byte stays on `tx_byte` until `tx_ready` is sampled high. A write while the register is occupied is dropped. A read of the transmit-data register returns the last word written to it.
- R8: Writing control with bit 0 set empties the transmit holding register.
- R9: The pending flag is sticky and only reset clears it. A transmit-data write sets it at the same edge. A non-empty receive FIFO sets it one cycle later.
- R10: `irq` is high exactly when the pending flag and control bit 4 are both set. A control read returns only bit 4.
- R11: Writes to the status and receive-data registers change nothing.
- R12: Synchronous active-high reset empties both directions and clears control, pending and overrun. Status then reads 0x04 and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr_en | input | 1 | Write strobe |
| bus_rd_en | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| rx_byte | input | BYTE_W | Incoming byte |
| rx_valid | input | 1 | Incoming byte valid |
| rx_ready | output | 1 | FIFO can take a byte |
| tx_byte | output | BYTE_W | Outgoing byte |
| tx_valid | output | 1 | Outgoing byte valid |
| tx_ready | input | 1 | Sink takes the outgoing byte |
| irq | output | 1 | Level interrupt |

## Verification
The receive path is filled one byte at a time up to full, with the status word read at each level. This separates the not-empty, full and pending bits. A ninth byte then shows the drop and the overrun bit, and a second status read shows the clear. A sweep of all 256 byte values in groups of eight drives the pointers through many wraps, so a wrong order or a lost byte shows up. A read while empty followed by a single push tells a saturating count from one that underflows. The transmit path is tried with the sink stalled, accepting and flushed, and the interrupt is tried with each of its two inputs missing in turn.

// File: rtl/sru_pkg.sv
package sru_pkg;
  typedef enum logic [1:0] {
    REG_RXDATA  = 2'd0,
    REG_TXDATA  = 2'd1,
    REG_STATUS  = 2'd2,
    REG_CONTROL = 2'd3
  } reg_sel_e;

  localparam int ST_RX_NONEMPTY = 0;
  localparam int ST_RX_FULL     = 1;
  localparam int ST_TX_EMPTY    = 2;
  localparam int ST_TX_BUSY     = 3;
  localparam int ST_PENDING     = 4;
  localparam int ST_OVERRUN     = 5;

  localparam int CTL_TX_FLUSH   = 0;
  localparam int CTL_RX_CLEAR   = 1;
  localparam int CTL_IRQ_EN     = 4;
endpackage

// File: rtl/sru_rx_fifo.sv
module sru_rx_fifo #(
  parameter int DEPTH = 8,
  parameter int W     = 8
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        clr,
  input  logic                        push,
  input  logic [W-1:0]                push_data,
  input  logic                        pop,
  output logic [W-1:0]                head,
  output logic [$clog2(DEPTH):0]      count,
  output logic                        empty,
  output logic                        full
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = PTR_W + 1;

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic             do_push, do_pop;

  assign do_push = push & ~clr;
  assign do_pop  = pop & ~clr;

  // storage without reset so it can map to memory
  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + CNT_W'(1);
        2'b01:   count <= count - CNT_W'(1);
        default: count <= count;
      endcase
    end
  end

  assign head  = mem[rd_ptr];
  assign empty = (count == '0);
  assign full  = (count == CNT_W'(DEPTH));
endmodule

// File: rtl/sru_tx_hold.sv
module sru_tx_hold #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         flush,
  input  logic         load,
  input  logic [W-1:0] load_data,
  input  logic         sink_ready,
  output logic         busy,
  output logic [W-1:0] data
);
  always_ff @(posedge clk) begin
    if (rst || flush) begin
      busy <= 1'b0;
      data <= '0;
    end else if (!busy && load) begin
      busy <= 1'b1;
      data <= load_data;
    end else if (busy && sink_ready) begin
      busy <= 1'b0;
    end
  end
endmodule

// File: rtl/sru_flags.sv
module sru_flags (
  input  logic clk,
  input  logic rst,
  input  logic ovr_set,
  input  logic ovr_clr,
  input  logic pend_set,
  input  logic irq_en,
  output logic overrun,
  output logic pending,
  output logic irq
);
  always_ff @(posedge clk) begin
    if (rst) begin
      overrun <= 1'b0;
      pending <= 1'b0;
    end else begin
      if (ovr_set)      overrun <= 1'b1;
      else if (ovr_clr) overrun <= 1'b0;
      if (pend_set)     pending <= 1'b1;
    end
  end

  assign irq = pending & irq_en;
endmodule

// File: rtl/serial_port_regs.sv
module serial_port_regs
  import sru_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 32,
  parameter int BYTE_W   = 8,
  parameter int RX_DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr_en,
  input  logic              bus_rd_en,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic              rx_valid,
  output logic              rx_ready,
  output logic [BYTE_W-1:0] tx_byte,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic              irq
);
  localparam int CNT_W = $clog2(RX_DEPTH) + 1;

  logic              in_range;
  reg_sel_e          sel;
  logic              wr_tx, wr_ctl, rd_rx, rd_st;
  logic              rx_push, rx_pop, rx_clear, rx_drop;
  logic [BYTE_W-1:0] rx_head;
  logic [CNT_W-1:0]  rx_count;
  logic              rx_empty, rx_full;
  logic              tx_flush;
  logic [DATA_W-1:0] tx_shadow;
  logic              ie_q;
  logic              pend_q, ovr_q;
  logic [DATA_W-1:0] status_w, ctrl_w, rd_mux;

  generate
    if (ADDR_W > 4) begin : g_upper
      assign in_range = ~|bus_addr[ADDR_W-1:4];
    end else begin : g_flat
      assign in_range = 1'b1;
    end
  endgenerate

  assign sel    = reg_sel_e'(bus_addr[3:2]);
  assign wr_tx  = bus_wr_en & in_range & (sel == REG_TXDATA);
  assign wr_ctl = bus_wr_en & in_range & (sel == REG_CONTROL);
  assign rd_rx  = bus_rd_en & in_range & (sel == REG_RXDATA);
  assign rd_st  = bus_rd_en & in_range & (sel == REG_STATUS);

  assign rx_ready = ~rx_full;
  assign rx_push  = rx_valid & ~rx_full;
  assign rx_drop  = rx_valid & rx_full;
  assign rx_pop   = rd_rx & ~rx_empty;
  assign rx_clear = wr_ctl & bus_wdata[CTL_RX_CLEAR];
  assign tx_flush = wr_ctl & bus_wdata[CTL_TX_FLUSH];

  sru_rx_fifo #(.DEPTH(RX_DEPTH), .W(BYTE_W)) u_rx_fifo (
    .clk(clk), .rst(rst), .clr(rx_clear),
    .push(rx_push), .push_data(rx_byte), .pop(rx_pop),
    .head(rx_head), .count(rx_count), .empty(rx_empty), .full(rx_full)
  );

  sru_tx_hold #(.W(BYTE_W)) u_tx_hold (
    .clk(clk), .rst(rst), .flush(tx_flush),
    .load(wr_tx), .load_data(bus_wdata[BYTE_W-1:0]),
    .sink_ready(tx_ready), .busy(tx_valid), .data(tx_byte)
  );

  sru_flags u_flags (
    .clk(clk), .rst(rst),
    .ovr_set(rx_drop), .ovr_clr(rd_st),
    .pend_set(wr_tx | ~rx_empty), .irq_en(ie_q),
    .overrun(ovr_q), .pending(pend_q), .irq(irq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ie_q      <= 1'b0;
      tx_shadow <= '0;
    end else begin
      if (wr_ctl) ie_q      <= bus_wdata[CTL_IRQ_EN];
      if (wr_tx)  tx_shadow <= bus_wdata;
    end
  end

  always_comb begin
    status_w                 = '0;
    status_w[ST_RX_NONEMPTY] = ~rx_empty;
    status_w[ST_RX_FULL]     = rx_full;
    status_w[ST_TX_EMPTY]    = ~tx_valid;
    status_w[ST_TX_BUSY]     = tx_valid;
    status_w[ST_PENDING]     = pend_q;
    status_w[ST_OVERRUN]     = ovr_q;
    ctrl_w                   = '0;
    ctrl_w[CTL_IRQ_EN]       = ie_q;
  end

  always_comb begin
    rd_mux = '0;
    if (in_range) begin
      case (sel)
        REG_RXDATA:  rd_mux = rx_empty ? '0 : DATA_W'(rx_head);
        REG_TXDATA:  rd_mux = tx_shadow;
        REG_STATUS:  rd_mux = status_w;
        REG_CONTROL: rd_mux = ctrl_w;
        default:     rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)            bus_rdata <= '0;
    else if (bus_rd_en) bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/sru_chk.sv
module sru_chk #(
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 32,
  parameter int BYTE_W   = 8,
  parameter int RX_DEPTH = 8
) (
  input logic                        clk,
  input logic                        rst,
  input logic                        bus_wr_en,
  input logic                        bus_rd_en,
  input logic [ADDR_W-1:0]           bus_addr,
  input logic [DATA_W-1:0]           bus_wdata,
  input logic                        rx_valid,
  input logic                        rx_ready,
  input logic                        tx_valid,
  input logic                        tx_ready,
  input logic [BYTE_W-1:0]           tx_byte,
  input logic                        irq,
  input logic [$clog2(RX_DEPTH):0]   count,
  input logic                        pend,
  input logic                        ie
);
  localparam int CNT_W = $clog2(RX_DEPTH) + 1;

  logic ctl_wr, rx_rd;
  assign ctl_wr = bus_wr_en && (bus_addr >> 2) == 3;
  assign rx_rd  = bus_rd_en && (bus_addr >> 2) == 0;

  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    count <= CNT_W'(RX_DEPTH));

  // R3
  full_ready_chk: assert property (@(posedge clk) disable iff (rst)
    (count == CNT_W'(RX_DEPTH)) |-> !rx_ready);

  // R5
  empty_read_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_rd && count == '0 && !rx_valid && !ctl_wr) |=> count == '0);

  // R7
  tx_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_ready && !(ctl_wr && bus_wdata[0])) |=> tx_valid && $stable(tx_byte));

  // R8
  tx_flush_chk: assert property (@(posedge clk) disable iff (rst)
    (ctl_wr && bus_wdata[0]) |=> !tx_valid);

  // R9
  pend_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    pend |=> pend);

  // R10
  irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> ie);
endmodule

bind serial_port_regs sru_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BYTE_W(BYTE_W), .RX_DEPTH(RX_DEPTH)
) u_sru_chk (
  .clk(clk), .rst(rst), .bus_wr_en(bus_wr_en), .bus_rd_en(bus_rd_en),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .rx_valid(rx_valid),
  .rx_ready(rx_ready), .tx_valid(tx_valid), .tx_ready(tx_ready),
  .tx_byte(tx_byte), .irq(irq), .count(rx_count), .pend(pend_q), .ie(ie_q)
);

// File: tb/test_serial_port_regs.sv
module test_serial_port_regs;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr_en = 1'b0, bus_rd_en = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [7:0]  rx_byte = '0;
  logic        rx_valid = 1'b0;
  logic        rx_ready;
  logic [7:0]  tx_byte;
  logic        tx_valid;
  logic        tx_ready = 1'b0;
  logic        irq;
  int          checks = 0, errors = 0;

  always #2 clk = ~clk;

  serial_port_regs i_serial_port_regs (
    .clk(clk), .rst(rst), .bus_wr_en(bus_wr_en), .bus_rd_en(bus_rd_en),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rx_byte(rx_byte), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .tx_byte(tx_byte), .tx_valid(tx_valid), .tx_ready(tx_ready), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr_en = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk); bus_wr_en = 1'b0;
  endtask

  task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd_en = 1'b1; bus_addr = a;
    @(posedge clk);
    @(negedge clk); bus_rd_en = 1'b0; d = bus_rdata;
  endtask

  task automatic push(input logic [7:0] b);
    @(negedge clk); rx_valid = 1'b1; rx_byte = b;
    @(posedge clk);
    @(negedge clk); rx_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] r;
    do_reset();
    // R12 reset state
    bus_read(4'h8, r); chk("R12 status", r, 32'h04);
    chk("R12 irq", {31'b0, irq}, 0);
    chk("R12 rx_ready", {31'b0, rx_ready}, 1);
    chk("R12 tx_valid", {31'b0, tx_valid}, 0);
    bus_read(4'hC, r); chk("R12 control", r, 0);
    bus_read(4'h4, r); chk("R1 tx readback after reset", r, 0);

    // R2 R3 R9 fill level sweep
    for (int n = 1; n <= 8; n++) begin
      push(8'((n * 29 + 3) & 8'hFF));
      bus_read(4'h8, r);
      chk("R2 status while filling", r, 32'h15 | (n == 8 ? 32'h2 : 32'h0));
      chk("R3 rx_ready level", {31'b0, rx_ready}, (n < 8) ? 1 : 0);
    end
    // R4 overrun on drop, cleared by status read
    push(8'hEE);
    bus_read(4'h8, r); chk("R4 overrun set", r, 32'h37);
    bus_read(4'h8, r); chk("R4 overrun cleared", r, 32'h17);
    // R3 R5 drain in order
    for (int k = 1; k <= 8; k++) begin
      bus_read(4'h0, r); chk("R3 fifo order", r, (k * 29 + 3) & 32'hFF);
    end
    bus_read(4'h8, r); chk("R2 empty status", r, 32'h14);
    bus_read(4'h0, r); chk("R5 empty read value", r, 0);
    push(8'h5A);
    bus_read(4'h8, r); chk("R5 no underflow count", r, 32'h15);
    bus_read(4'h0, r); chk("R5 byte after empty read", r, 32'h5A);
    bus_read(4'h8, r); chk("R5 empty again", r, 32'h14);

    // R3 full byte sweep with pointer wrap
    for (int g = 0; g < 32; g++) begin
      for (int j = 0; j < 8; j++) push(8'(g * 8 + j));
      for (int j = 0; j < 8; j++) begin
        bus_read(4'h0, r); chk("R3 sweep data", r, 32'(g * 8 + j));
      end
    end

    // R6 receive clear
    push(8'h11); push(8'h22); push(8'h33);
    bus_write(4'hC, 32'h2);
    bus_read(4'h8, r); chk("R6 fifo cleared", r, 32'h14);
    chk("R6 rx_ready after clear", {31'b0, rx_ready}, 1);
    bus_read(4'hC, r); chk("R10 control shows bit4 only", r, 0);

    // R11 ignored writes
    bus_write(4'h8, 32'hFFFF_FFFF);
    bus_write(4'h0, 32'hAB);
    bus_read(4'h8, r); chk("R11 status unchanged", r, 32'h14);
    bus_read(4'h0, r); chk("R11 rx write ignored", r, 0);

    // R10 gate by enable
    chk("R10 irq off without enable", {31'b0, irq}, 0);
    bus_write(4'hC, 32'h10);
    chk("R10 irq on with enable", {31'b0, irq}, 1);
    bus_read(4'hC, r); chk("R10 control readback", r, 32'h10);

    // R9 pending from transmit write
    do_reset();
    bus_write(4'hC, 32'h10);
    repeat (2) @(negedge clk);
    chk("R9 no pending without cause", {31'b0, irq}, 0);
    bus_write(4'h4, 32'h141);
    chk("R9 tx write sets pending", {31'b0, irq}, 1);
    chk("R7 tx_valid", {31'b0, tx_valid}, 1);
    chk("R7 tx_byte", {24'b0, tx_byte}, 32'h41);
    bus_read(4'h8, r); chk("R2 tx busy status", r, 32'h18);
    bus_write(4'h4, 32'h77);
    chk("R7 write while busy dropped", {24'b0, tx_byte}, 32'h41);
    bus_read(4'h4, r); chk("R7 tx readback last written", r, 32'h77);
    @(negedge clk); tx_ready = 1'b1;
    @(posedge clk);
    @(negedge clk); tx_ready = 1'b0;
    chk("R7 accepted byte leaves", {31'b0, tx_valid}, 0);
    bus_read(4'h8, r); chk("R2 tx empty again", r, 32'h14);
    // R8 transmit flush
    bus_write(4'h4, 32'h66);
    chk("R7 reload", {24'b0, tx_byte}, 32'h66);
    bus_write(4'hC, 32'h11);
    chk("R8 flush clears tx", {31'b0, tx_valid}, 0);
    bus_read(4'hC, r); chk("R10 control after flush", r, 32'h10);
    chk("R9 pending sticky", {31'b0, irq}, 1);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule